// File: doc/BRIEF.md
# Data cache maintenance controller

This block carries out the maintenance operations of a write-back data cache. Software writes five registers. A control word holds an invalidate-mode bit and shows a read-only flush-busy flag. Two trigger registers start a walk over the whole cache. Two more registers take a byte address and act on the one line that address selects. The block keeps a small tag store with a valid bit, a dirty bit and an address tag for each line. A sequencer walks that store and sends each line that must be written back to a simple request/acknowledge memory port.

There are two commands. Flush writes dirty lines back and leaves them valid. Invalidate drops lines. The mode bit decides what invalidate does with dirty data. With the bit clear, dirty data is thrown away. With the bit set, each dirty line is written back before it is dropped, so setting the bit turns invalidate into flush-and-invalidate. The mode is captured when a request is written. A request that needs no write-back finishes at once. Any other request raises the busy flag, and software polls that flag to learn that the request has finished.

The fill port stands in for the cache's normal refill and store path. It loads a line's tag and sets the line's dirty state. The probe port reads back one line's valid and dirty bits.

Top module: `dcache_maint`

## Requirements
- R1: After reset, every line is invalid, the control word reads 0 and `wb_req` is low.
- R2: Writing select 0 (control) stores `reg_wdata` bit 0 as the invalidate mode. The control word returns the mode in bit 0 and busy in bit 1. Busy cannot be written.
- R3: Whole-cache flush (select 2) writes back every valid dirty line exactly once, in ascending index order. The write-back address is the line base {tag, index, zero offset}. Afterwards the lines are still valid and are clean.
- R4: Whole-cache invalidate (select 1) with the mode clear makes every line invalid, issues no write-back and never raises busy.
- R5: Whole-cache invalidate with the mode set writes back the valid dirty lines in ascending index order, then leaves every line invalid.
- R6: Per-line flush (select 4, byte address in `reg_wdata`) issues a write-back only if the indexed line is valid, dirty and has a matching tag. Afterwards that line is valid and clean.
- R7: Per-line invalidate (select 3) with the mode clear drops the line without a write-back when its tag matches. When the tag does not match, the line is left unchanged.
- R8: Per-line invalidate with the mode set writes the matching line back if it is dirty, then drops it.
- R9: Busy reads 1 from the cycle after a flush or a flush-and-invalidate is written until that operation ends, and 0 afterwards. Busy is high whenever `wb_req` is high.
- R10: A request written while busy is held and runs after the current walk finishes. A single slot holds it, so a later request replaces an earlier held one.
- R11: Once `wb_req` is raised, it and `wb_addr` stay fixed until the cycle in which `wb_ack` is seen.
- R12: The whole-cache trigger registers start an operation only when bit 0 of the written word is 1. Writing 0 to them changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 control, 1 invalidate all, 2 flush all, 3 invalidate line, 4 flush line |
| reg_wdata | input | ADDR_W | Write data or line byte address |
| ctrl_rdata | output | ADDR_W | Control word: bit 0 mode, bit 1 busy |
| fill_en | input | 1 | Load one line from the normal cache path |
| fill_addr | input | ADDR_W | Byte address of the loaded line |
| fill_dirty | input | 1 | Dirty state of the loaded line |
| probe_idx | input | log2(LINES) | Line index to observe |
| probe_valid | output | 1 | Valid bit of the probed line |
| probe_dirty | output | 1 | Dirty bit of the probed line |
| wb_req | output | 1 | Write-back request |
| wb_addr | output | ADDR_W | Base address of the line being written back |
| wb_ack | input | 1 | Write-back accepted |

## Verification
The hardest case to reach is a request that arrives while a walk is already running, and the replacement of that request by a newer one. From the ports this is visible only as the order of write-backs and as the line state left behind. The stimulus starts a whole-cache flush while acknowledges are delayed, so the walk takes many cycles. It then writes one or two further requests during the walk. It probes the lines at once to show the held request has not acted yet. It probes them again after busy falls, to show which request ran. A scoreboard holds the expected write-back addresses, computed from a reference copy of the line state. Comparing against it checks both the order and the absence of extra write-backs.

// File: rtl/dcm_pkg.sv
package dcm_pkg;
  typedef enum logic [2:0] {
    SEL_CTRL       = 3'd0,
    SEL_INV_ALL    = 3'd1,
    SEL_FLUSH_ALL  = 3'd2,
    SEL_INV_LINE   = 3'd3,
    SEL_FLUSH_LINE = 3'd4
  } reg_sel_e;

  typedef enum logic [1:0] {WK_IDLE, WK_SCAN, WK_WB} walk_state_e;

  typedef enum logic {OP_FLUSH = 1'b0, OP_INV = 1'b1} op_kind_e;
endpackage

// File: rtl/dcm_req_slot.sv
module dcm_req_slot
  import dcm_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_sel,
  input  logic [ADDR_W-1:0] reg_wdata,
  input  logic              take,
  output logic              mode_q,
  output logic              slot_v,
  output op_kind_e          slot_kind,
  output logic              slot_whole,
  output logic              slot_mode,
  output logic [ADDR_W-1:0] slot_addr
);
  logic     new_v;
  op_kind_e new_kind;
  logic     new_whole;

  always_comb begin
    new_v     = 1'b0;
    new_kind  = OP_FLUSH;
    new_whole = 1'b0;
    case (reg_sel_e'(reg_sel))
      SEL_INV_ALL:    begin new_v = reg_we && reg_wdata[0]; new_kind = OP_INV;   new_whole = 1'b1; end
      SEL_FLUSH_ALL:  begin new_v = reg_we && reg_wdata[0]; new_kind = OP_FLUSH; new_whole = 1'b1; end
      SEL_INV_LINE:   begin new_v = reg_we;                 new_kind = OP_INV;   end
      SEL_FLUSH_LINE: begin new_v = reg_we;                 new_kind = OP_FLUSH; end
      default:        new_v = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q     <= 1'b0;
      slot_v     <= 1'b0;
      slot_kind  <= OP_FLUSH;
      slot_whole <= 1'b0;
      slot_mode  <= 1'b0;
      slot_addr  <= '0;
    end else begin
      if (reg_we && reg_sel_e'(reg_sel) == SEL_CTRL) mode_q <= reg_wdata[0];
      if (new_v) begin
        slot_v     <= 1'b1;
        slot_kind  <= new_kind;
        slot_whole <= new_whole;
        slot_mode  <= mode_q;
        slot_addr  <= reg_wdata;
      end else if (take) begin
        slot_v <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dcm_tag_store.sv
module dcm_tag_store #(
  parameter int LINES = 64,
  parameter int IDX_W = 6,
  parameter int TAG_W = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             fill_dirty,
  input  logic             clr_all,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_clr_v,
  input  logic             upd_clr_d,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_v,
  output logic             rd_d,
  output logic [TAG_W-1:0] rd_tag,
  input  logic [IDX_W-1:0] probe_idx,
  output logic             probe_v,
  output logic             probe_d,
  output logic [LINES-1:0] all_v
);
  logic [LINES-1:0] all_d;
  logic [TAG_W-1:0] tags [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic             lv, ld;
    logic [TAG_W-1:0] lt;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lv <= 1'b0;
        ld <= 1'b0;
        lt <= '0;
      end else begin
        if (clr_all) begin
          lv <= 1'b0;
          ld <= 1'b0;
        end
        if (upd_en && upd_idx == IDX_W'(g)) begin
          if (upd_clr_v) lv <= 1'b0;
          if (upd_clr_d) ld <= 1'b0;
        end
        if (fill_en && fill_idx == IDX_W'(g)) begin
          lv <= 1'b1;
          ld <= fill_dirty;
          lt <= fill_tag;
        end
      end
    end
    assign all_v[g] = lv;
    assign all_d[g] = ld;
    assign tags[g]  = lt;
  end

  assign rd_v    = all_v[rd_idx];
  assign rd_d    = all_d[rd_idx];
  assign rd_tag  = tags[rd_idx];
  assign probe_v = all_v[probe_idx];
  assign probe_d = all_d[probe_idx];
endmodule

// File: rtl/dcm_walker.sv
module dcm_walker
  import dcm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LINES  = 64,
  parameter int IDX_W  = 6,
  parameter int OFS_W  = 5,
  parameter int TAG_W  = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_v,
  input  op_kind_e          slot_kind,
  input  logic              slot_whole,
  input  logic              slot_mode,
  input  logic [ADDR_W-1:0] slot_addr,
  output logic              take,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic              rd_v,
  input  logic              rd_d,
  input  logic [TAG_W-1:0]  rd_tag,
  output logic              upd_en,
  output logic              upd_clr_v,
  output logic              upd_clr_d,
  output logic              clr_all,
  output logic              wb_req,
  output logic [ADDR_W-1:0] wb_addr,
  input  logic              wb_ack,
  output logic              walk_active,
  output logic              walk_done
);
  function automatic logic [IDX_W-1:0] line_idx(input logic [ADDR_W-1:0] a);
    return a[OFS_W +: IDX_W];
  endfunction

  function automatic logic [TAG_W-1:0] line_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  function automatic logic [ADDR_W-1:0] line_base(input logic [TAG_W-1:0] t,
                                                  input logic [IDX_W-1:0] i);
    return {t, i, {OFS_W{1'b0}}};
  endfunction

  walk_state_e       st_q, st_d;
  op_kind_e          kind_q;
  logic              whole_q;
  logic [TAG_W-1:0]  tag_q;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] wb_addr_q;

  logic idle, slot_pure, cur_whole, line_hit, last, step, start_walk;
  logic [TAG_W-1:0] cur_tag;

  assign idle       = (st_q == WK_IDLE);
  assign slot_pure  = slot_v && slot_kind == OP_INV && !slot_mode;
  assign start_walk = idle && slot_v && !slot_pure;
  assign cur_tag    = idle ? line_tag(slot_addr) : tag_q;
  assign cur_whole  = idle ? slot_whole : whole_q;
  assign rd_idx     = idle ? line_idx(slot_addr) : idx_q;
  assign line_hit   = rd_v && (cur_whole || rd_tag == cur_tag);
  assign last       = !whole_q || idx_q == IDX_W'(LINES - 1);

  always_comb begin
    st_d      = st_q;
    take      = 1'b0;
    upd_en    = 1'b0;
    upd_clr_v = 1'b0;
    upd_clr_d = 1'b0;
    clr_all   = 1'b0;
    step      = 1'b0;
    case (st_q)
      WK_IDLE: begin
        take = slot_v;
        if (slot_pure) begin
          if (slot_whole) clr_all = 1'b1;
          else if (line_hit) begin
            upd_en = 1'b1; upd_clr_v = 1'b1; upd_clr_d = 1'b1;
          end
        end else if (slot_v) begin
          st_d = WK_SCAN;
        end
      end
      WK_SCAN: begin
        if (line_hit && rd_d) begin
          st_d = WK_WB;
        end else begin
          if (line_hit && kind_q == OP_INV) begin
            upd_en = 1'b1; upd_clr_v = 1'b1; upd_clr_d = 1'b1;
          end
          step = 1'b1;
        end
      end
      WK_WB: begin
        if (wb_ack) begin
          upd_en    = 1'b1;
          upd_clr_d = 1'b1;
          upd_clr_v = (kind_q == OP_INV);
          step      = 1'b1;
        end
      end
      default: st_d = WK_IDLE;
    endcase
    if (step && last) st_d = WK_IDLE;
    if (step && !last) st_d = WK_SCAN;
  end

  assign walk_done = step && last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= WK_IDLE;
      kind_q    <= OP_FLUSH;
      whole_q   <= 1'b0;
      tag_q     <= '0;
      idx_q     <= '0;
      wb_addr_q <= '0;
    end else begin
      st_q <= st_d;
      if (start_walk) begin
        kind_q  <= slot_kind;
        whole_q <= slot_whole;
        tag_q   <= line_tag(slot_addr);
        idx_q   <= slot_whole ? '0 : line_idx(slot_addr);
      end
      if (st_q == WK_SCAN && st_d == WK_WB) wb_addr_q <= line_base(rd_tag, idx_q);
      if (step && !last) idx_q <= idx_q + 1'b1;
    end
  end

  assign wb_req      = (st_q == WK_WB);
  assign wb_addr     = wb_addr_q;
  assign walk_active = !idle;
endmodule

// File: rtl/dcache_maint.sv
module dcache_maint
  import dcm_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINES      = 64,
  parameter int LINE_BYTES = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_we,
  input  logic [2:0]                 reg_sel,
  input  logic [ADDR_W-1:0]          reg_wdata,
  output logic [ADDR_W-1:0]          ctrl_rdata,
  input  logic                       fill_en,
  input  logic [ADDR_W-1:0]          fill_addr,
  input  logic                       fill_dirty,
  input  logic [$clog2(LINES)-1:0]   probe_idx,
  output logic                       probe_valid,
  output logic                       probe_dirty,
  output logic                       wb_req,
  output logic [ADDR_W-1:0]          wb_addr,
  input  logic                       wb_ack
);
  localparam int IDX_W = $clog2(LINES);
  localparam int OFS_W = $clog2(LINE_BYTES);
  localparam int TAG_W = ADDR_W - IDX_W - OFS_W;

  logic              mode_q, slot_v, slot_whole, slot_mode, take;
  op_kind_e          slot_kind;
  logic [ADDR_W-1:0] slot_addr;
  logic [IDX_W-1:0]  rd_idx;
  logic              rd_v, rd_d;
  logic [TAG_W-1:0]  rd_tag;
  logic              upd_en, upd_clr_v, upd_clr_d;
  logic              clr_all_w, walk_active, walk_done_w, busy_w;
  logic [LINES-1:0]  line_v_w;

  dcm_req_slot #(.ADDR_W(ADDR_W)) u_slot (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .take(take), .mode_q(mode_q), .slot_v(slot_v),
    .slot_kind(slot_kind), .slot_whole(slot_whole), .slot_mode(slot_mode),
    .slot_addr(slot_addr)
  );

  dcm_tag_store #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .fill_en(fill_en), .fill_idx(fill_addr[OFS_W +: IDX_W]),
    .fill_tag(fill_addr[ADDR_W-1 -: TAG_W]), .fill_dirty(fill_dirty),
    .clr_all(clr_all_w), .upd_en(upd_en), .upd_idx(rd_idx),
    .upd_clr_v(upd_clr_v), .upd_clr_d(upd_clr_d),
    .rd_idx(rd_idx), .rd_v(rd_v), .rd_d(rd_d), .rd_tag(rd_tag),
    .probe_idx(probe_idx), .probe_v(probe_valid), .probe_d(probe_dirty),
    .all_v(line_v_w)
  );

  dcm_walker #(.ADDR_W(ADDR_W), .LINES(LINES), .IDX_W(IDX_W), .OFS_W(OFS_W),
               .TAG_W(TAG_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .slot_v(slot_v), .slot_kind(slot_kind),
    .slot_whole(slot_whole), .slot_mode(slot_mode), .slot_addr(slot_addr),
    .take(take), .rd_idx(rd_idx), .rd_v(rd_v), .rd_d(rd_d), .rd_tag(rd_tag),
    .upd_en(upd_en), .upd_clr_v(upd_clr_v), .upd_clr_d(upd_clr_d),
    .clr_all(clr_all_w), .wb_req(wb_req), .wb_addr(wb_addr), .wb_ack(wb_ack),
    .walk_active(walk_active), .walk_done(walk_done_w)
  );

  // Busy covers a running walk and a held request that will need write-back.
  assign busy_w     = walk_active || (slot_v && (slot_kind == OP_FLUSH || slot_mode));
  assign ctrl_rdata = ADDR_W'({busy_w, mode_q});
endmodule

// File: rtl/dcache_maint_chk.sv
module dcache_maint_chk #(
  parameter int ADDR_W = 32,
  parameter int LINES  = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wb_req,
  input logic              wb_ack,
  input logic [ADDR_W-1:0] wb_addr,
  input logic              busy,
  input logic              clr_all,
  input logic              fill_en,
  input logic              walk_done,
  input logic [LINES-1:0]  valid_vec
);
  // R11: request and address hold until acknowledged
  p_wb_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req && !wb_ack |=> wb_req && $stable(wb_addr));

  // R9: a write-back is only outstanding while busy reads 1
  p_wb_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req |-> busy);

  // R4: a whole-cache discard leaves no valid line behind
  p_inv_all_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all && !fill_en |=> valid_vec == '0);

  // R3: each acknowledge retires exactly one write-back
  p_one_wb_per_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req && wb_ack |=> !wb_req);

  // R9: the end of a walk is never reached while a write-back waits
  p_done_no_wb_r9: assert property (@(posedge clk) disable iff (!rst_n)
    walk_done |-> !(wb_req && !wb_ack));
endmodule

bind dcache_maint dcache_maint_chk #(.ADDR_W(ADDR_W), .LINES(LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .wb_req(wb_req), .wb_ack(wb_ack),
  .wb_addr(wb_addr), .busy(busy_w), .clr_all(clr_all_w), .fill_en(fill_en),
  .walk_done(walk_done_w), .valid_vec(line_v_w)
);

// File: tb/test_dcache_maint.sv
`timescale 1ns/1ps
module test_dcache_maint;
  localparam int LINES = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] ctrl_rdata;
  logic        fill_en = 1'b0;
  logic [31:0] fill_addr = '0;
  logic        fill_dirty = 1'b0;
  logic [5:0]  probe_idx = '0;
  logic        probe_valid, probe_dirty;
  logic        wb_req;
  logic [31:0] wb_addr;
  logic        wb_ack = 1'b0;

  always #4 clk = ~clk;

  dcache_maint i_dcache_maint (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .ctrl_rdata(ctrl_rdata), .fill_en(fill_en),
    .fill_addr(fill_addr), .fill_dirty(fill_dirty), .probe_idx(probe_idx),
    .probe_valid(probe_valid), .probe_dirty(probe_dirty), .wb_req(wb_req),
    .wb_addr(wb_addr), .wb_ack(wb_ack)
  );

  int n_checks = 0, n_fail = 0;
  bit done = 0;
  bit ref_v [LINES];
  bit ref_d [LINES];
  logic [20:0] ref_t [LINES];
  bit tb_mode = 0;
  logic [31:0] exp_q [$];
  int dly = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [20:0] t, input int i);
    return {t, 6'(i), 5'b0};
  endfunction

  // Monitor/responder: acknowledges after two waiting cycles and scores the address
  always @(negedge clk) begin
    if (wb_ack) begin
      wb_ack = 1'b0;
      dly = 0;
    end else if (wb_req) begin
      if (dly == 2) begin
        wb_ack = 1'b1;
        if (exp_q.size() == 0) chk(0, "R3", "unexpected write-back", wb_addr, 32'h0);
        else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          chk(wb_addr == e, "R3", "write-back address/order", wb_addr, e);
        end
      end else dly++;
    end
  end

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic fill(input logic [20:0] t, input int i, input bit dirty);
    @(negedge clk);
    fill_en = 1'b1; fill_addr = mk(t, i); fill_dirty = dirty;
    @(negedge clk);
    fill_en = 1'b0;
    ref_v[i] = 1; ref_d[i] = dirty; ref_t[i] = t;
  endtask

  task automatic set_mode(input bit m);
    wr(3'd0, {31'b0, m});
    tb_mode = m;
  endtask

  // Driver: updates the reference copy and pushes expected write-backs
  task automatic op(input logic [2:0] sel, input logic [31:0] a);
    bit inv, whole;
    inv   = (sel == 3'd1 || sel == 3'd3);
    whole = (sel == 3'd1 || sel == 3'd2);
    for (int i = 0; i < LINES; i++) begin
      bit hit;
      hit = ref_v[i] && (whole ? 1'b1 : (i == int'(a[10:5]) && ref_t[i] == a[31:11]));
      if (hit) begin
        if (ref_d[i] && (!inv || tb_mode)) exp_q.push_back(mk(ref_t[i], i));
        ref_d[i] = 0;
        if (inv) ref_v[i] = 0;
      end
    end
    wr(sel, a);
  endtask

  task automatic wait_idle();
    @(negedge clk); @(negedge clk);
    while (ctrl_rdata[1]) @(negedge clk);
    @(negedge clk); @(negedge clk);
  endtask

  task automatic check_lines(input string req);
    for (int i = 0; i < LINES; i++) begin
      probe_idx = 6'(i);
      #0.1;
      chk(probe_valid == ref_v[i] && probe_dirty == ref_d[i], req,
          $sformatf("line %0d {valid,dirty}", i),
          {30'b0, probe_valid, probe_dirty}, {30'b0, ref_v[i], ref_d[i]});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      chk(0, "WATCHDOG", "run did not finish", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < LINES; i++) begin ref_v[i] = 0; ref_d[i] = 0; ref_t[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(ctrl_rdata == 32'h0, "R1", "control word after reset", ctrl_rdata, 32'h0);
    chk(wb_req == 1'b0, "R1", "wb_req after reset", {31'b0, wb_req}, 32'h0);
    check_lines("R1");

    // R2: mode bit writable, busy bit read-only
    wr(3'd0, 32'h3);
    @(negedge clk);
    chk(ctrl_rdata == 32'h1, "R2", "control readback", ctrl_rdata, 32'h1);
    set_mode(0);
    @(negedge clk);
    chk(ctrl_rdata == 32'h0, "R2", "mode cleared", ctrl_rdata, 32'h0);

    // R3/R9: whole flush in index order
    fill(21'h1A5, 3, 1); fill(21'h0B0, 10, 0); fill(21'h1C3, 40, 1);
    fill(21'h0D7, 63, 1); fill(21'h0E1, 0, 1);
    op(3'd2, 32'h1);
    chk(ctrl_rdata[1] == 1'b1, "R9", "busy right after flush write", ctrl_rdata, 32'h2);
    wait_idle();
    chk(ctrl_rdata[1] == 1'b0, "R9", "busy cleared on completion", ctrl_rdata, 32'h0);
    chk(exp_q.size() == 0, "R3", "all write-backs seen", exp_q.size(), 0);
    check_lines("R3");

    // R7: per-line discard, hit and tag miss
    fill(21'h011, 5, 1); fill(21'h022, 7, 1);
    op(3'd3, mk(21'h011, 5));
    op(3'd3, mk(21'h099, 7));
    wait_idle();
    chk(ctrl_rdata[1] == 1'b0, "R7", "no busy for discard", ctrl_rdata, 32'h0);
    check_lines("R7");

    // R6: per-line flush of dirty hit and clean line
    op(3'd4, mk(21'h022, 7));
    wait_idle();
    op(3'd4, mk(21'h0B0, 10));
    wait_idle();
    chk(exp_q.size() == 0, "R6", "line flush write-backs", exp_q.size(), 0);
    check_lines("R6");

    // R8: per-line flush-and-invalidate
    set_mode(1);
    fill(21'h033, 20, 1);
    op(3'd3, mk(21'h033, 20));
    wait_idle();
    chk(exp_q.size() == 0, "R8", "line flush-invalidate write-back", exp_q.size(), 0);
    check_lines("R8");

    // R12: zero written to whole-cache triggers is ignored
    wr(3'd1, 32'h0);
    wr(3'd2, 32'h0);
    wait_idle();
    check_lines("R12");

    // R10: held request runs after the walk
    set_mode(0);
    fill(21'h044, 1, 1); fill(21'h055, 2, 1);
    op(3'd2, 32'h1);
    op(3'd1, 32'h1);
    for (int i = 0; i < 3; i++) begin
      probe_idx = 6'(i + 1);
      #0.1;
      chk(probe_valid == 1'b1, "R10", "line still valid while request held",
          {31'b0, probe_valid}, 32'h1);
    end
    wait_idle();
    check_lines("R10");

    // R10: a newer held request replaces the older one
    fill(21'h066, 8, 1); fill(21'h077, 9, 1);
    op(3'd2, 32'h1);
    wr(3'd1, 32'h1);                 // replaced before it can run
    op(3'd4, mk(21'h066, 8));
    wait_idle();
    check_lines("R10");

    // R4: whole discard, busy never seen
    fill(21'h088, 12, 1); fill(21'h0AA, 33, 0);
    op(3'd1, 32'h1);
    for (int i = 0; i < 4; i++) begin
      chk(ctrl_rdata[1] == 1'b0, "R4", "busy during discard", ctrl_rdata, 32'h0);
      @(negedge clk);
    end
    check_lines("R4");

    // R5: whole flush-and-invalidate
    set_mode(1);
    fill(21'h101, 4, 1); fill(21'h102, 50, 1); fill(21'h103, 9, 0);
    op(3'd1, 32'h1);
    chk(ctrl_rdata[1] == 1'b1, "R5", "busy during flush-invalidate", ctrl_rdata, 32'h3);
    wait_idle();
    chk(exp_q.size() == 0, "R5", "write-backs seen", exp_q.size(), 0);
    check_lines("R5");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule